// File: doc/BRIEF.md
# Capture-to-RAM transfer controller

This block moves captured 32-bit data words into system RAM. Each capture event carries one word. An accepted word enters a four-entry holding FIFO. From there it is written to RAM through a bus-master write port. Other masters can hold that port off for any number of cycles. The FIFO soaks up those stalls, so a capture does not have to wait for the bus.

A transfer is armed by a start event. In software mode the start is a 0-to-1 edge on the capture-enable level. In external mode it is an external event pulse, sampled through one flop. The start loads:
- the transfer length into a down-counting transfer counter and into a capture-credit counter;
- both destination address counters from their base inputs;
- the destination selector, which picks the address counter that is used.

Each completed RAM write moves the active address counter up by 4 and lowers the transfer counter by 1. When the transfer counter reaches zero it stops.

An 8-bit status register reports five events:
- the end of the transfer, once per destination and once overall;
- a capture lost to a full FIFO;
- a start request that arrives while a transfer is still running.

The status register is cleared through a small register write port, and an interrupt line is high while any status bit is set.

Back-pressure rules:
- The write port is valid/ready. `wr_valid` stays high, and `wr_addr` and `wr_data` stay constant, until a cycle with `wr_ready` high completes the write.
- The capture input has no ready. A capture arriving at a full FIFO is dropped and flagged, never stalled.

Top module: `capture_xfer_ctrl`

## Requirements
- R1: After reset, `reg_rdata` is 0x00, `irq` is low and `wr_valid` is low.
- R2: Status layout:
  - bit 0 is the destination-0 end flag and bit 1 the destination-1 end flag;
  - bit 2 is the overrun flag and bit 3 the start-error flag;
  - bit 4 is the transfer-end flag;
  - bits 7..5 always read 0.
- R3: A register write clears each status bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1 unchanged.
- R4: If hardware sets a status bit in the same cycle that a register write clears it, the bit ends up 1.
- R5: A start with the transfer counter at zero has two effects:
  - it loads the transfer counter and the capture credit with `xfer_len`, both address counters from `base0`/`base1`, and the destination from `dst_sel` (0 selects `base0`, 1 selects `base1`);
  - after it, a capture (`cap_valid` high) is accepted only while capture is enabled and credit remains, and each accepted capture uses one credit. Capture is enabled when `ext_sel` is high, or when `ext_sel` is low and `cap_en_sw` is high.
- R6: Words are written in arrival order. While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold.
- R7: Each completed write (`wr_valid` and `wr_ready` both high) adds 4 to the active address counter, which drives `wr_addr`, and lowers the transfer counter by 1.
- R8: The write that takes the transfer counter from 1 to 0 sets status bit 4 and also sets bit 0 or bit 1, according to the active destination.
- R9: An accepted-eligible capture that arrives while the FIFO holds four words sets status bit 2 and is discarded. The fullness test uses the count before any write completing in that cycle.
- R10: With `ext_sel` low, a 0-to-1 edge of `cap_en_sw` while the transfer counter is nonzero sets status bit 3. No reload happens.
- R11: With `ext_sel` high:
  - an `ext_evt` pulse acts one cycle later, and `cap_en_sw` has no effect;
  - the pulse starts a transfer if the transfer counter is zero;
  - otherwise it sets status bit 3 and is ignored.
- R12: `irq` is high exactly when any status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Capture event with a data word |
| cap_data | input | DW | Captured word |
| wr_valid | output | 1 | RAM write request pending |
| wr_ready | input | 1 | RAM write grant |
| wr_addr | output | AW | RAM byte address of the pending write |
| wr_data | output | DW | Word of the pending write |
| cap_en_sw | input | 1 | Software capture-enable level |
| ext_sel | input | 1 | Selects the external start source |
| ext_evt | input | 1 | External start event pulse |
| xfer_len | input | CW | Transfer length loaded at start |
| base0 | input | AW | Start address of destination 0 |
| base1 | input | AW | Start address of destination 1 |
| dst_sel | input | 1 | Destination chosen at start |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status write data (0 clears) |
| reg_rdata | output | 8 | Status register value |
| irq | output | 1 | Interrupt request |

## Verification
The bench looks for several failure modes:
- A fifth capture that lands on a full FIFO. A design with an off-by-one in its fullness test would either overwrite the oldest word or raise overrun one capture early.
- A status write of all zeros in the same cycle as that overrun. A design that lets the clear win would lose the event.
- A second start request in each mode while a transfer runs. A design that reloads on it would restart the address sequence. A design that ignores it would leave bit 3 clear.
- The final write in each destination. A design that fires the end flags one write early, or on the wrong destination bit, would show it there.
- Long grant stalls. A design whose address or data moves during a stall would show it there.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int STAT_W = 8;
  localparam int NFLAG  = 5;
  localparam int N_DST  = 2;
  localparam int F_D0   = 0;
  localparam int F_D1   = 1;
  localparam int F_OVR  = 2;
  localparam int F_SERR = 3;
  localparam int F_END  = 4;
endpackage

// File: rtl/cx_fifo.sv
module cx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [NW-1:0] cnt;
  logic          do_wr, do_rd;

  assign full  = (cnt == NW'(DEPTH));
  assign empty = (cnt == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign dout  = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= nxt(wp);
      if (do_rd) rp <= nxt(rp);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + NW'(1);
        2'b01:   cnt <= cnt - NW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= din;
  end
endmodule

// File: rtl/cx_down.sv
module cx_down #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          last
);
  assign last = dec && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= val;
    else if (dec && cnt != '0) cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/cx_addr_bank.sv
module cx_addr_bank #(
  parameter int AW   = 32,
  parameter int NDST = 2,
  localparam int SW  = (NDST > 1) ? $clog2(NDST) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [NDST*AW-1:0] bases,
  input  logic [SW-1:0]      sel,
  input  logic               adv,
  output logic [AW-1:0]      addr
);
  logic [AW-1:0] av [NDST];

  for (genvar g = 0; g < NDST; g++) begin : g_ctr
    logic [AW-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        r <= '0;
      else if (load)                     r <= bases[g*AW +: AW];
      else if (adv && sel == SW'(g))     r <= r + AW'(4);
    end
    assign av[g] = r;
  end

  assign addr = av[sel];
endmodule

// File: rtl/cx_status.sv
module cx_status
  import cx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAG-1:0]  hw_set,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] rdata,
  output logic              irq
);
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] clr;

  assign clr = reg_wr ? ~reg_wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | hw_set;
  end

  assign rdata = {{(STAT_W - NFLAG){1'b0}}, flags};
  assign irq   = |flags;
endmodule

// File: rtl/capture_xfer_ctrl.sv
module capture_xfer_ctrl
  import cx_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_valid,
  input  logic [DW-1:0] cap_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          cap_en_sw,
  input  logic          ext_sel,
  input  logic          ext_evt,
  input  logic [CW-1:0] xfer_len,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] base1,
  input  logic          dst_sel,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq
);
  logic          en_q, ext_q, dst_q;
  logic          sw_rise, ext_hit, start_req, busy, start;
  logic          cap_gate, cap_take, push, full, empty, hs;
  logic [CW-1:0] tcnt, credit;
  logic          tc_last, cr_last;
  logic [NFLAG-1:0] hw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ext_q <= 1'b0;
      dst_q <= 1'b0;
    end else begin
      en_q  <= cap_en_sw;
      ext_q <= ext_evt;
      if (start) dst_q <= dst_sel;
    end
  end

  assign sw_rise   = !ext_sel && cap_en_sw && !en_q;
  assign ext_hit   = ext_sel && ext_q;
  assign start_req = sw_rise || ext_hit;
  assign busy      = (tcnt != '0);
  assign start     = start_req && !busy;

  assign cap_gate = (ext_sel || cap_en_sw) && (credit != '0);
  assign cap_take = cap_valid && cap_gate;
  assign push     = cap_take && !full;
  assign wr_valid = !empty;
  assign hs       = wr_valid && wr_ready;

  cx_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(cap_data),
    .pop(hs), .dout(wr_data), .full(full), .empty(empty)
  );

  cx_down #(.CW(CW)) u_tcnt (
    .clk(clk), .rst_n(rst_n), .load(start), .val(xfer_len),
    .dec(hs), .cnt(tcnt), .last(tc_last)
  );

  cx_down #(.CW(CW)) u_credit (
    .clk(clk), .rst_n(rst_n), .load(start), .val(xfer_len),
    .dec(push), .cnt(credit), .last(cr_last)
  );

  cx_addr_bank #(.AW(AW), .NDST(N_DST)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(start), .bases({base1, base0}),
    .sel(dst_q), .adv(hs), .addr(wr_addr)
  );

  always_comb begin
    hw_set         = '0;
    hw_set[F_D0]   = tc_last && !dst_q;
    hw_set[F_D1]   = tc_last && dst_q;
    hw_set[F_OVR]  = cap_take && full;
    hw_set[F_SERR] = start_req && busy;
    hw_set[F_END]  = tc_last;
  end

  cx_status u_stat (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .rdata(reg_rdata), .irq(irq)
  );

  logic unused_ok;
  assign unused_ok = cr_last;
endmodule

// File: rtl/cx_checker.sv
module cx_checker #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_valid,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          reg_wr,
  input logic [7:0]    reg_wdata,
  input logic [7:0]    reg_rdata,
  input logic          irq
);
  a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid);

  a_r6_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> ($stable(wr_data) && $stable(wr_addr)));

  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!wr_valid || wr_addr == $past(wr_addr) + AW'(4)));

  a_r8_end_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[4]) |-> $past(wr_valid && wr_ready));

  a_r9_ovr_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[2]) |-> $past(cap_valid));

  a_r3_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[3] && reg_rdata[3]) |=> reg_rdata[3]);

  a_r12_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (reg_rdata != 8'h00));
endmodule

bind capture_xfer_ctrl cx_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
);

// File: tb/sim_capture_xfer_ctrl.sv
module sim_capture_xfer_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_valid = 1'b0;
  logic [31:0] cap_data = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic        cap_en_sw = 1'b0, ext_sel = 1'b0, ext_evt = 1'b0;
  logic [15:0] xfer_len = '0;
  logic [31:0] base0 = '0, base1 = '0;
  logic        dst_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  capture_xfer_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_data(cap_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_en_sw(cap_en_sw), .ext_sel(ext_sel), .ext_evt(ext_evt),
    .xfer_len(xfer_len), .base0(base0), .base1(base1), .dst_sel(dst_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // Reference model
  logic [31:0] q[$];
  logic [15:0] m_tcnt, m_left;
  logic [31:0] m_a[2];
  int          m_dst;
  logic [4:0]  m_stat;
  logic        m_enq, m_extq;

  always @(posedge clk) begin
    bit busy, full, hs, sreq, take;
    logic [4:0] set, clr;
    if (!rst_n) begin
      q.delete();
      m_tcnt = 0; m_left = 0; m_a[0] = 0; m_a[1] = 0; m_dst = 0;
      m_stat = 0; m_enq = 0; m_extq = 0;
    end else begin
      busy = (m_tcnt != 0);
      full = (q.size() == DEPTH);
      hs   = (q.size() != 0) && wr_ready;
      sreq = (!ext_sel && cap_en_sw && !m_enq) || (ext_sel && m_extq);
      take = cap_valid && (ext_sel || cap_en_sw) && (m_left != 0);
      set  = '0;
      if (sreq && busy) set[3] = 1'b1;
      if (take && full) set[2] = 1'b1;
      if (hs) begin
        void'(q.pop_front());
        m_a[m_dst] += 4;
        if (m_tcnt == 1) begin
          set[4] = 1'b1;
          set[m_dst] = 1'b1;
        end
        m_tcnt--;
      end
      if (take && !full) begin
        q.push_back(cap_data);
        m_left--;
      end
      if (sreq && !busy) begin
        m_tcnt = xfer_len; m_left = xfer_len;
        m_a[0] = base0; m_a[1] = base1; m_dst = int'(dst_sel);
      end
      clr = reg_wr ? ~reg_wdata[4:0] : 5'd0;
      m_stat = (m_stat & ~clr) | set;
      m_enq = cap_en_sw;
      m_extq = ext_evt;
    end
  end

  function automatic string stat_req(input logic [7:0] d);
    if (d[7:5] != 0) return "R2";
    if (d[2]) return "R9";
    if (d[3]) return "R10";
    return "R8";
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 valid", {31'd0, wr_valid}, {31'd0, q.size() != 0});
      if (wr_valid && q.size() != 0) begin
        chk("R6 data", wr_data, q[0]);
        chk("R7 addr", wr_addr, m_a[m_dst]);
      end
      chk({stat_req(reg_rdata ^ {3'b0, m_stat}), " status"}, {24'd0, reg_rdata}, {27'd0, m_stat});
      chk("R12 irq", {31'd0, irq}, {31'd0, m_stat != 0});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cap(input logic [31:0] d);
    cap_valid = 1'b1; cap_data = d;
    step(1);
    cap_valid = 1'b0;
  endtask

  task automatic wr_stat(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  initial begin
    step(3);
    chk("R1 rdata", {24'd0, reg_rdata}, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R1 valid", {31'd0, wr_valid}, 32'h0);
    rst_n = 1'b1;
    step(1);

    // R5 software start, destination 1
    xfer_len = 16'd3; base0 = 32'h1000; base1 = 32'h2000; dst_sel = 1'b1;
    cap_en_sw = 1'b1;
    step(1);
    cap(32'hA1); cap(32'hA2); cap(32'hA3); cap(32'hA4);
    chk("R5 valid", {31'd0, wr_valid}, 32'h1);
    chk("R5 first addr", wr_addr, 32'h2000);
    chk("R6 first data", wr_data, 32'hA1);
    step(3);
    chk("R6 stall hold data", wr_data, 32'hA1);
    wr_ready = 1'b1;
    step(1);
    chk("R7 next addr", wr_addr, 32'h2004);
    step(2);
    wr_ready = 1'b0;
    chk("R5 credit limit", {31'd0, wr_valid}, 32'h0);
    chk("R8 dest1 end", {24'd0, reg_rdata}, 32'h12);
    chk("R12 irq high", {31'd0, irq}, 32'h1);

    // R3 write-0 clears, write-1 keeps
    wr_stat(8'hFD);
    chk("R3 clear bit1", {24'd0, reg_rdata}, 32'h10);
    wr_stat(8'hFF);
    chk("R3 ones keep", {24'd0, reg_rdata}, 32'h10);
    wr_stat(8'h00);
    chk("R3 clear all", {24'd0, reg_rdata}, 32'h0);

    // R10 start error in software mode
    cap_en_sw = 1'b0; step(1);
    xfer_len = 16'd6; base0 = 32'h100; dst_sel = 1'b0;
    cap_en_sw = 1'b1; step(1);
    cap_en_sw = 1'b0; step(1);
    base0 = 32'h900;
    cap_en_sw = 1'b1; step(1);
    chk("R10 start error", {24'd0, reg_rdata}, 32'h08);

    // R9 overrun with R4 simultaneous clear
    cap(32'hB1); cap(32'hB2); cap(32'hB3); cap(32'hB4);
    chk("R10 no reload", wr_addr, 32'h100);
    cap_valid = 1'b1; cap_data = 32'hB5; reg_wr = 1'b1; reg_wdata = 8'h00;
    step(1);
    cap_valid = 1'b0; reg_wr = 1'b0;
    chk("R4 set wins, R9 overrun", {24'd0, reg_rdata}, 32'h04);
    wr_ready = 1'b1;
    step(4);
    wr_ready = 1'b0;
    chk("R9 dropped word", {31'd0, wr_valid}, 32'h0);
    chk("R7 not terminal", {24'd0, reg_rdata}, 32'h04);
    wr_stat(8'h00);
    cap(32'hB6); cap(32'hB7);
    chk("R7 addr after four", wr_addr, 32'h110);
    wr_ready = 1'b1;
    step(2);
    wr_ready = 1'b0;
    chk("R8 dest0 end", {24'd0, reg_rdata}, 32'h11);
    wr_stat(8'h00);

    // R11 external mode
    cap_en_sw = 1'b0; ext_sel = 1'b1;
    xfer_len = 16'd2; base1 = 32'h300; dst_sel = 1'b1;
    ext_evt = 1'b1; step(1); ext_evt = 1'b0;
    step(1);
    chk("R11 ext start clean", {24'd0, reg_rdata}, 32'h0);
    cap(32'hC1); cap(32'hC2);
    chk("R11 ext capture", wr_addr, 32'h300);
    ext_evt = 1'b1; step(1); ext_evt = 1'b0;
    step(1);
    chk("R11 ext error", {24'd0, reg_rdata}, 32'h08);
    wr_ready = 1'b1;
    step(2);
    wr_ready = 1'b0;
    chk("R11 ext end", {24'd0, reg_rdata}, 32'h1A);
    wr_stat(8'h00);

    // Random traffic, both modes, model-compared every cycle
    for (int i = 0; i < 800; i++) begin
      ext_sel   = (i >= 400);
      cap_valid = ($urandom % 3) == 0;
      cap_data  = $urandom;
      wr_ready  = ($urandom % 3) != 0;
      reg_wr    = ($urandom % 8) == 0;
      reg_wdata = 8'($urandom);
      if (($urandom % 12) == 0) cap_en_sw = ~cap_en_sw;
      ext_evt   = ext_sel && (($urandom % 25) == 0);
      xfer_len  = 16'($urandom % 9);
      dst_sel   = 1'($urandom);
      base0     = {$urandom} & 32'hFFFF_FFFC;
      base1     = {$urandom} & 32'hFFFF_FFFC;
      step(1);
    end
    cap_valid = 1'b0; reg_wr = 1'b0; ext_evt = 1'b0;
    step(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule